// File: doc/BRIEF.md
# Multi-Field Binary Polynomial Reducer

This block takes the unreduced double-width product of a GF(2^m) multiplication and returns its remainder modulo the irreducible polynomial of the selected field. Three fixed reduction networks sit side by side, one each for m = 163, 233 and 283. A 2-bit field select picks which network drives the registered output. Each network is XOR-only combinational logic. It splits the product into a low part (bits below m) and an overlap part (bits m and up), and folds the overlap back into the low part twice. Because each polynomial's second-highest term lies below m/2, two folds always leave a result of degree below m.

The product enters on a 566-bit bus. It is zero-padded at the top when a smaller field is used. The remainder leaves on a 283-bit bus, zero above bit m-1, one clock after an input strobe. There is no backpressure: every strobed input yields exactly one output strobe.

Top module: `multi_field_reducer`

## Requirements
- R1: With field select 0 the result is the product modulo x^163 + x^7 + x^6 + x^3 + 1.
- R2: With field select 1 the result is the product modulo x^233 + x^74 + 1.
- R3: With field select 2 the result is the product modulo x^283 + x^12 + x^7 + x^5 + 1.
- R4: Field select 3 yields an all-zero result with the error flag high. Select codes 0, 1 and 2 give an error flag of low.
- R5: Result bits at positions m and above are zero for the selected field.
- R6: Product bits at positions 2m-1 and above have no effect on the result for field m.
- R7: out_valid_o is high exactly one cycle after in_valid_i was high. The result and error flag change only in that cycle, and hold otherwise.
- R8: After reset, out_valid_o, result_o and sel_err_o are all zero.
- R9: A product with no bit set at or above position m passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Product strobe |
| field_sel_i | input | 2 | Field select: 0=163, 1=233, 2=283, 3=invalid |
| prod_i | input | 566 | Unreduced product |
| out_valid_o | output | 1 | Result strobe, one cycle after in_valid_i |
| result_o | output | 283 | Reduced element, zero-padded above m |
| sel_err_o | output | 1 | Invalid field select seen with the last strobe |

## Verification
The assertions assume the field select and product are only meaningful in cycles where in_valid_i is high. They also assume reset holds long enough to clear the output register before the first strobe. The bench drives inputs at the falling edge and strobes in_valid_i for a single cycle per operation. In idle cycles it deliberately changes field_sel_i and prod_i, so the hold behaviour is tested against inputs that are not strobed. The products are random, all-ones, below-degree-m and junk-above-2m-1 patterns, and each result is compared with a bit-serial long-division model.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
  localparam int W    = 283;
  localparam int IN_W = 2 * W;
  localparam int NFLD = 3;

  // per-field modulus: x^M + x^K1 (+ x^K2 + x^K3 when PENTA) + 1
  localparam int FLD_M     [NFLD] = '{163, 233, 283};
  localparam int FLD_K1    [NFLD] = '{7, 74, 12};
  localparam int FLD_K2    [NFLD] = '{6, 0, 7};
  localparam int FLD_K3    [NFLD] = '{3, 0, 5};
  localparam bit FLD_PENTA [NFLD] = '{1'b1, 1'b0, 1'b1};

  typedef enum logic [1:0] {
    FSEL_163 = 2'd0,
    FSEL_233 = 2'd1,
    FSEL_283 = 2'd2,
    FSEL_BAD = 2'd3
  } fsel_e;
endpackage

// File: rtl/mfr_fold_red.sv
module mfr_fold_red #(
  parameter int W     = 283,
  parameter int M     = 163,
  parameter int K1    = 7,
  parameter int K2    = 6,
  parameter int K3    = 3,
  parameter bit PENTA = 1'b1
) (
  input  logic [2*W-1:0] prod_i,
  output logic [W-1:0]   rem_o
);
  localparam int CW = 2 * M;
  localparam logic [CW-1:0] LO_MASK = {{M{1'b0}}, {M{1'b1}}};

  // one fold: lo ^ hi*(x^K1 [+ x^K2 + x^K3] + 1)
  function automatic logic [CW-1:0] fold(input logic [CW-1:0] v);
    logic [CW-1:0] hi, r;
    hi = v >> M;
    r  = (v & LO_MASK) ^ hi ^ (hi << K1);
    if (PENTA) r = r ^ (hi << K2) ^ (hi << K3);
    return r;
  endfunction

  logic [CW-1:0] c, t1, t2;

  always_comb begin
    c          = '0;
    c[CW-2:0]  = prod_i[CW-2:0];  // bits >= 2M-1 dropped
    t1         = fold(c);
    t2         = fold(t1);
    rem_o      = '0;
    rem_o[M-1:0] = t2[M-1:0];
  end
endmodule

// File: rtl/mfr_sel_mux.sv
module mfr_sel_mux
  import mfr_pkg::*;
(
  input  logic [NFLD-1:0][W-1:0] cand_i,
  input  logic [1:0]             fsel_i,
  output logic [W-1:0]           res_o,
  output logic                   err_o
);
  always_comb begin
    res_o = '0;
    err_o = 1'b0;
    unique case (fsel_e'(fsel_i))
      FSEL_163: res_o = cand_i[0];
      FSEL_233: res_o = cand_i[1];
      FSEL_283: res_o = cand_i[2];
      default:  err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/multi_field_reducer.sv
module multi_field_reducer
  import mfr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [1:0]      field_sel_i,
  input  logic [IN_W-1:0] prod_i,
  output logic            out_valid_o,
  output logic [W-1:0]    result_o,
  output logic            sel_err_o
);
  logic [NFLD-1:0][W-1:0] cand;
  logic [W-1:0]           mux_res;
  logic                   mux_err;

  for (genvar gi = 0; gi < NFLD; gi++) begin : g_fld
    logic [W-1:0] rem;
    mfr_fold_red #(
      .W(W), .M(FLD_M[gi]), .K1(FLD_K1[gi]), .K2(FLD_K2[gi]),
      .K3(FLD_K3[gi]), .PENTA(FLD_PENTA[gi])
    ) u_red (
      .prod_i(prod_i),
      .rem_o (rem)
    );
    assign cand[gi] = rem;
  end

  mfr_sel_mux u_mux (
    .cand_i(cand),
    .fsel_i(field_sel_i),
    .res_o (mux_res),
    .err_o (mux_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      sel_err_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o  <= mux_res;
        sel_err_o <= mux_err;
      end
    end
  end
endmodule

// File: rtl/mfr_checker.sv
module mfr_checker
  import mfr_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic [1:0]      field_sel_i,
  input logic [IN_W-1:0] prod_i,
  input logic            out_valid_o,
  input logic [W-1:0]    result_o,
  input logic            sel_err_o
);
  a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(result_o) && $stable(sel_err_o)));

  a_r4_bad_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && field_sel_i == 2'd3) |=> (sel_err_o && result_o == '0));

  a_r4_good_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && field_sel_i != 2'd3) |=> !sel_err_o);

  a_r5_top_clear_163: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && field_sel_i == 2'd0) |=> (result_o[W-1:163] == '0));

  a_r5_top_clear_233: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && field_sel_i == 2'd1) |=> (result_o[W-1:233] == '0));

  a_r9_passthru_283: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && field_sel_i == 2'd2 && prod_i[IN_W-1:W] == '0)
      |=> (result_o == $past(prod_i[W-1:0])));
endmodule

bind multi_field_reducer mfr_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .field_sel_i(field_sel_i),
  .prod_i     (prod_i),
  .out_valid_o(out_valid_o),
  .result_o   (result_o),
  .sel_err_o  (sel_err_o)
);

// File: tb/sim_multi_field_reducer.sv
`timescale 1ns/1ps
module sim_multi_field_reducer;
  localparam int W  = 283;
  localparam int IW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    fsel = 2'd0;
  logic [IW-1:0] prod = '0;
  logic          out_valid;
  logic [W-1:0]  result;
  logic          sel_err;
  int            n_chk = 0;
  int            n_err = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  multi_field_reducer u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .field_sel_i(fsel),
    .prod_i(prod), .out_valid_o(out_valid), .result_o(result), .sel_err_o(sel_err)
  );

  function automatic logic [IW-1:0] poly_of(int m);
    logic [IW-1:0] p = '0;
    p[m] = 1'b1; p[0] = 1'b1;
    case (m)
      163: begin p[7] = 1'b1; p[6] = 1'b1; p[3] = 1'b1; end
      233: p[74] = 1'b1;
      default: begin p[12] = 1'b1; p[7] = 1'b1; p[5] = 1'b1; end
    endcase
    return p;
  endfunction

  // bit-serial long division
  function automatic logic [W-1:0] ref_mod(logic [IW-1:0] p, int m);
    logic [IW-1:0] r = p;
    logic [IW-1:0] q = poly_of(m);
    for (int i = 0; i < IW; i++) if (i >= 2*m-1) r[i] = 1'b0;
    for (int i = 2*m-2; i >= m; i--) if (r[i]) r = r ^ (q << (i - m));
    return r[W-1:0];
  endfunction

  function automatic logic [IW-1:0] rnd_prod();
    logic [575:0] t;
    for (int k = 0; k < 18; k++) t[k*32 +: 32] = $urandom;
    return t[IW-1:0];
  endfunction

  function automatic int m_of(logic [1:0] s);
    return (s == 2'd0) ? 163 : (s == 2'd1) ? 233 : 283;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic [IW-1:0] p);
    @(negedge clk);
    in_valid = 1'b1; fsel = s; prod = p;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0 && sel_err == 1'b0 && result == '0, "R8 reset",
          result, '0);
  endtask

  task automatic t_field(input logic [1:0] s, input string req, input int n);
    logic [W-1:0] e;
    logic [IW-1:0] p;
    for (int k = 0; k <= n; k++) begin
      p = (k == n) ? '1 : rnd_prod();
      drive(s, p);
      e = ref_mod(p, m_of(s));
      check(out_valid && !sel_err && result == e, req, result, e);
      check(result >> m_of(s) == '0, "R5 top bits clear", result, e);
    end
  endtask

  task automatic t_bad_sel();
    drive(2'd3, rnd_prod());
    check(out_valid && sel_err && result == '0, "R4 code 3", result, '0);
    drive(2'd1, rnd_prod());
    check(!sel_err, "R4 flag clears", {282'd0, sel_err}, '0);
  endtask

  task automatic t_upper_ignored();
    logic [IW-1:0] p, pm;
    logic [W-1:0]  e;
    for (int s = 0; s < 2; s++) begin
      p  = rnd_prod();
      pm = p & ((IW'(1) << (2*m_of(2'(s)) - 1)) - IW'(1));
      e  = ref_mod(pm, m_of(2'(s)));
      drive(2'(s), p);
      check(result == e, "R6 upper junk ignored", result, e);
    end
  endtask

  task automatic t_passthru();
    logic [IW-1:0] p;
    for (int s = 0; s < 3; s++) begin
      p = rnd_prod() & ((IW'(1) << m_of(2'(s))) - IW'(1));
      drive(2'(s), p);
      check(result == p[W-1:0], "R9 passthru", result, p[W-1:0]);
    end
  endtask

  task automatic t_hold();
    logic [W-1:0] held;
    drive(2'd2, rnd_prod());
    held = result;
    @(negedge clk);
    fsel = 2'd3; prod = rnd_prod();
    @(posedge clk); #1;
    check(!out_valid, "R7 valid drops", {282'd0, out_valid}, '0);
    @(posedge clk); #1;
    check(result == held && !sel_err, "R7 result holds", result, held);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_field(2'd0, "R1 field 163", 8);
    t_field(2'd1, "R2 field 233", 8);
    t_field(2'd2, "R3 field 283", 8);
    t_bad_sel();
    t_upper_ignored();
    t_passthru();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule